// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Interface

This block collects a set of interrupt lines and reduces them to one request line toward a processor. Each line is fixed at build time as either rising-edge or active-high level sensitive. Events are captured in a status register, filtered through a per-line enable register, and reported through a pending view and a vector register. The vector register returns the number of the line to service next, or all ones when nothing needs service.

Software reaches the block through a plain 32-bit register port. The port has a word index, a write strobe, write data and a combinational read-data output. Enable bits can be replaced in one write, or changed one bit at a time through write-one set and clear aliases. Status bits are cleared by writing ones to the acknowledge register. A two-bit master register gates the request output.

Word indices (byte offset = index × 4): 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and master read 0, the vector reads 0xFFFFFFFF and irqReq is 0. Registers are selected by the word indices listed above.
- R2: A write to the enable register (index 2) replaces every enable bit; writing 0 disables all lines.
- R3: A write to set-enable (index 4) sets each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to clear-enable (index 5) clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: A write to acknowledge (index 3) clears each status bit whose data bit is 1; writing 0xFFFFFFFF clears them all.
- R6: A line whose KIND_MASK bit is 1 sets its status bit on a rising edge only. Holding the line high after an acknowledge does not set the bit again.
- R7: A line whose KIND_MASK bit is 0 sets its status bit in every cycle it is high. An acknowledge while the line is still high leaves the bit set.
- R8: Status bits latch whether or not the line is enabled. Pending (index 1) reads status AND enable.
- R9: The vector (index 6) reads the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R10: Master bit 0 is the master enable and bit 1 is the hardware enable. Writing 0x3 reads back 0x3. irqReq is 1 only when both bits are 1 and some line is pending.
- R11: Bits at or above NUM_IN in status, pending and enable read 0, and writes to those bits have no effect.
- R12: A rising edge on an edge line in the same cycle as an acknowledge of that bit leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IN | Interrupt lines |
| busWordAddr | input | 3 | Register word index |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the selected register |
| irqReq | output | 1 | Request to the processor |

## Verification
The bench targets an acknowledge that lands while a level line is still high. A design that lets the clear win would drop the bit and lose the interrupt. It also targets an edge line held high after its acknowledge; a design that treats the line as a level would set the bit again and service the interrupt twice. An acknowledge in the same cycle as a fresh rising edge must keep that edge, so a wrong priority shows up as a status bit reading 0. The bench also drains several pending lines in turn to expose a wrong priority order. It writes all ones to a block built with fewer than 32 lines to catch bits above the line count that read back. Finally, it tries each partial master setting to catch an output that asserts when only one enable bit is set.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } regSel_e;

  typedef struct packed {
    logic enWr;
    logic enSet;
    logic enClr;
    logic ack;
    logic masterWr;
  } wrStrb_t;
endpackage

// File: rtl/irq_vec_decode.sv
`timescale 1ns/1ps
module irq_vec_decode
  import irq_vec_pkg::*;
(
  input  logic [2:0] busWordAddr,
  input  logic       busWrEn,
  output wrStrb_t    strb,
  output regSel_e    rdSel
);
  always_comb begin
    rdSel = regSel_e'(busWordAddr);
    strb  = '0;
    if (busWrEn) begin
      unique case (rdSel)
        SEL_ENABLE: strb.enWr     = 1'b1;
        SEL_SETEN:  strb.enSet    = 1'b1;
        SEL_CLREN:  strb.enClr    = 1'b1;
        SEL_ACK:    strb.ack      = 1'b1;
        SEL_MASTER: strb.masterWr = 1'b1;
        default:    strb          = '0;
      endcase
    end
  end

  // R2..R5, R10: at most one strobe per write
  always_comb begin
    a_r5_one_strobe: assert ($countones(strb) <= 1)
      else $error("more than one write strobe");
  end
endmodule

// File: rtl/irq_vec_core.sv
`timescale 1ns/1ps
module irq_vec_core
  import irq_vec_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  wrStrb_t           strb,
  input  regSel_e           rdSel,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              irqReq
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam logic [NUM_IN-1:0] EDGE_M = KIND_MASK[NUM_IN-1:0];

  logic [NUM_IN-1:0] prevQ, statusQ, enableQ, pendVec;
  logic [NUM_IN-1:0] riseEvt, lvlEvt, setEvt, ackMask, wrBits;
  logic [1:0]        masterQ;
  logic              vecHit;
  logic [IDX_W-1:0]  vecIdx;

  assign wrBits  = wrData[NUM_IN-1:0];
  assign riseEvt = irqIn & ~prevQ & EDGE_M;
  assign lvlEvt  = irqIn & ~EDGE_M;
  assign setEvt  = riseEvt | lvlEvt;
  assign ackMask = strb.ack ? wrBits : '0;
  assign pendVec = statusQ & enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
    end else begin
      prevQ   <= irqIn;
      statusQ <= (statusQ & ~ackMask) | setEvt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strb.enWr) begin
      enableQ <= wrBits;
    end else if (strb.enSet) begin
      enableQ <= enableQ | wrBits;
    end else if (strb.enClr) begin
      enableQ <= enableQ & ~wrBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) masterQ <= 2'b00;
    else if (strb.masterWr) masterQ <= wrData[1:0];
  end

  always_comb begin
    vecHit = 1'b0;
    vecIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        vecHit = 1'b1;
        vecIdx = IDX_W'(i);
      end
    end
  end

  assign irqReq = (&masterQ) & (|pendVec);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_STATUS: rdData = BUS_W'(statusQ);
      SEL_PEND:   rdData = BUS_W'(pendVec);
      SEL_ENABLE: rdData = BUS_W'(enableQ);
      SEL_VECTOR: rdData = vecHit ? BUS_W'(vecIdx) : '1;
      SEL_MASTER: rdData = BUS_W'(masterQ);
      default:    rdData = '0;
    endcase
  end

  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enableQ & $past(wrBits)) == $past(wrBits)))
    else $error("set-enable did not set bits");

  a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enableQ & $past(wrBits)) == '0))
    else $error("clear-enable did not clear bits");

  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(irqIn & ~EDGE_M)) == $past(irqIn & ~EDGE_M)))
    else $error("high level line lost its status bit");

  a_r12_edge_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && (|riseEvt)) |=> ((statusQ & $past(riseEvt)) == $past(riseEvt)))
    else $error("acknowledge overrode a same-cycle edge");

  a_r9_vector_lowest: assert property (@(posedge clk) disable iff (!rstN)
    vecHit |-> (pendVec[vecIdx] &&
               ((pendVec & ((NUM_IN'(1) << vecIdx) - NUM_IN'(1))) == '0)))
    else $error("vector is not the lowest pending line");
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [2:0]        busWordAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irqReq
);
  wrStrb_t strb;
  regSel_e rdSel;

  irq_vec_decode u_decode (
    .busWordAddr (busWordAddr),
    .busWrEn     (busWrEn),
    .strb        (strb),
    .rdSel       (rdSel)
  );

  irq_vec_core #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_core (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (busWrData),
    .rdData (busRdData),
    .irqReq (irqReq)
  );
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  localparam int          N    = 20;
  localparam logic [31:0] KIND = 32'h0000_00F0; // lines 4..7 edge, rest level

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqIn = '0;
  logic [2:0]    busWordAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          irqReq;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isReq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_IN(N), .KIND_MASK(KIND)) i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWordAddr(busWordAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq)
  );

  // monitor: pops expected items and compares after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.isReq ? {31'b0, irqReq} : busRdData;
        nChecks++;
        if (act !== it.exp) begin
          nErr++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = idx; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setIn(input logic [N-1:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  task automatic ackWithEdge(input logic [N-1:0] v, input logic [31:0] d);
    @(negedge clk);
    irqIn = v; busWrEn = 1'b1; busWordAddr = 3'd3; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [2:0] idx, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busWordAddr = idx;
    it.isReq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expReq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.isReq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expRd(3'd0, 32'h0, "R1 status");
    expRd(3'd2, 32'h0, "R1 enable");
    expRd(3'd7, 32'h0, "R1 master");
    expRd(3'd6, 32'hFFFF_FFFF, "R1 vector");
    expReq(1'b0, "R1 irqReq");
    // R10 master readback
    wr(3'd7, 32'h3);
    expRd(3'd7, 32'h3, "R10 master");
    // R2 direct enable
    wr(3'd2, 32'h5);
    expRd(3'd2, 32'h5, "R2 enable");
    wr(3'd2, 32'h0);
    expRd(3'd2, 32'h0, "R2 disable all");
    // R3 / R4 aliases
    wr(3'd4, 32'h0A);
    expRd(3'd2, 32'h0A, "R3 set");
    wr(3'd4, 32'h01);
    expRd(3'd2, 32'h0B, "R3 set keep");
    wr(3'd5, 32'h02);
    expRd(3'd2, 32'h09, "R4 clear");
    // R11 upper bits
    wr(3'd2, 32'hFFFF_FFFF);
    expRd(3'd2, 32'h000F_FFFF, "R11 enable width");
    wr(3'd2, 32'h0);
    // R8 latch while disabled
    setIn(N'(32'h200));
    expRd(3'd0, 32'h200, "R8 status");
    expRd(3'd1, 32'h0, "R8 pending masked");
    expRd(3'd6, 32'hFFFF_FFFF, "R9 none");
    expReq(1'b0, "R10 nothing pending");
    wr(3'd4, 32'h200);
    expRd(3'd1, 32'h200, "R8 pending");
    expRd(3'd6, 32'd9, "R9 vector");
    expReq(1'b1, "R10 request");
    // R7 level re-latch
    wr(3'd3, 32'h200);
    expRd(3'd0, 32'h200, "R7 level held");
    setIn('0);
    wr(3'd3, 32'h200);
    expRd(3'd0, 32'h0, "R5 ack");
    expRd(3'd6, 32'hFFFF_FFFF, "R9 empty");
    // R6 edge held high
    setIn(N'(32'h20));
    expRd(3'd0, 32'h20, "R6 edge latch");
    wr(3'd3, 32'h20);
    expRd(3'd0, 32'h0, "R6 no relatch");
    setIn('0);
    expRd(3'd0, 32'h0, "R6 fall");
    // R9 priority
    wr(3'd2, 32'h000F_FFFF);
    setIn(N'(32'h1044));
    setIn('0);
    expRd(3'd6, 32'd2, "R9 lowest");
    wr(3'd3, 32'h4);
    expRd(3'd6, 32'd6, "R9 next");
    wr(3'd3, 32'h40);
    expRd(3'd6, 32'd12, "R9 last");
    wr(3'd3, 32'hFFFF_FFFF);
    expRd(3'd6, 32'hFFFF_FFFF, "R9 drained");
    expRd(3'd0, 32'h0, "R5 ack all");
    // R10 partial master
    wr(3'd7, 32'h1);
    setIn(N'(32'h8));
    expReq(1'b0, "R10 only master");
    wr(3'd7, 32'h3);
    expReq(1'b1, "R10 both");
    wr(3'd7, 32'h2);
    expReq(1'b0, "R10 only hw");
    expRd(3'd7, 32'h2, "R10 master read");
    setIn('0);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'h3);
    // R5 partial ack of several edges
    setIn(N'(32'hF0));
    setIn('0);
    expRd(3'd0, 32'hF0, "R6 four edges");
    wr(3'd3, 32'h30);
    expRd(3'd0, 32'hC0, "R5 partial ack");
    wr(3'd3, 32'hFFFF_FFFF);
    expRd(3'd0, 32'h0, "R5 all");
    // R12 edge beats ack
    setIn(N'(32'h10));
    setIn('0);
    expRd(3'd0, 32'h10, "R12 setup");
    ackWithEdge(N'(32'h10), 32'h10);
    expRd(3'd0, 32'h10, "R12 edge wins");
    setIn('0);
    wr(3'd3, 32'h10);
    expRd(3'd0, 32'h0, "R12 plain ack");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule